// File: doc/BRIEF.md
# Self-Checking Systematic (15,7) LDPC Encoder

This block turns a 7-bit data word into a 15-bit codeword of the cyclic (15,7) Euclidean-geometry LDPC code, whose minimum distance is 5. The generator polynomial is g(x) = 1 + x^4 + x^6 + x^7 + x^8. The codeword is laid out in systematic form. The data bits pass through unchanged into the low seven positions. The upper eight positions carry parity bits, and each parity bit is an XOR of a fixed subset of the data bits.

The XOR network can suffer a transient fault, so its output is not trusted. Every freshly encoded word goes straight into a syndrome checker made from the 15x15 circulant parity-check matrix. An OR of the fifteen syndrome bits gives the error flag. When the flag is clear, the word is released on a one-cycle strobe together with the number of re-encodes it took. When the flag is set, the word is encoded again. After three failed attempts the word is dropped and a sticky failure flag is raised.

A fault-injection input inverts one chosen parity bit for each attempt during which it is held high. This allows the retry path to be exercised on purpose.

Top module: `ldpc_selfcheck_enc`

## Requirements
- R1: A released codeword carries the accepted data word unchanged in bits [6:0].
- R2: A released codeword equals the unique multiple of g(x) (a 15-bit polynomial, bit i = coefficient of x^i) whose bits [6:0] match the data. Data 0 gives 15'h0000 and data 7'h7F gives 15'h7FFF.
- R3: Every released codeword has an all-zero syndrome. Check k (k = 0..14) is the XOR of bits k, k-4, k-6 and k-7, with indices taken modulo 15.
- R4: A word is accepted at a rising edge where in_valid and in_ready are both 1. in_ready stays 0 from that edge until the word is released or dropped. Each attempt takes one cycle. When attempt a (counting from 0) is clean, cw_valid is high for one cycle after the (a+1)-th rising edge following acceptance.
- R5: When flip_req is 1 during an attempt cycle, codeword bit 7+flip_idx is inverted for that attempt only. The checker flags that attempt and the word is encoded again. cw_retries shows the number of flagged attempts that came before the release.
- R6: When MAX_TRIES (3) consecutive attempts are all flagged, no strobe is given and enc_fail is set. in_ready returns to 1 after the third attempt's edge.
- R7: enc_fail stays set until reset. While it is set, later words are still encoded and released normally.
- R8: After reset, in_ready is 1, cw_valid is 0 and enc_fail is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Data word offered |
| in_ready | output | 1 | Encoder idle, can accept a word |
| in_data | input | 7 | Data word |
| flip_req | input | 1 | Invert one parity bit during the current attempt |
| flip_idx | input | 3 | Parity bit to invert (codeword bit 7+flip_idx) |
| cw_valid | output | 1 | One-cycle strobe for a released codeword |
| cw_data | output | 15 | Released codeword |
| cw_retries | output | 2 | Re-encodes needed for the released codeword |
| enc_fail | output | 1 | Sticky flag: a word was dropped after the retry limit |

## Verification
The in-module assertions check several properties on every cycle. Each released word keeps the data bits and has a zero syndrome. The strobe never lasts longer than one cycle. The retry count stays below the limit. The failure flag never falls, and it rises only in a cycle without a strobe. The bench's scenarios cover the remaining behaviour. They confirm that the parity bits are exactly those of the code, that an injected flip costs exactly one attempt, and that the strobe arrives in the predicted cycle. They also confirm that three flagged attempts drop the word, and that encoding continues after the sticky flag is set.

// File: rtl/ldpc_selfcheck_enc.sv
module ldpc_selfcheck_enc #(
  parameter int MAX_TRIES = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [6:0]  in_data,
  input  logic        flip_req,
  input  logic [2:0]  flip_idx,
  output logic        cw_valid,
  output logic [14:0] cw_data,
  output logic [1:0]  cw_retries,
  output logic        enc_fail
);
  localparam int K = 7;
  localparam int N = 15;
  localparam int P = N - K;
  localparam logic [P:0] GPOLY = 9'h1D1;

  function automatic logic [N-1:0] encode(input logic [K-1:0] d);
    logic [P:0]   r;
    logic [P-1:0] par;
    r   = 9'h0D1;
    par = '0;
    for (int j = 0; j < K; j++) begin
      if (d[j]) par = par ^ r[P-1:0];
      r = {r[P-1:0], 1'b0};
      if (r[P]) r = r ^ GPOLY;
    end
    return {par, d};
  endfunction

  function automatic logic [N-1:0] syndrome(input logic [N-1:0] c);
    logic [N-1:0] s;
    for (int k = 0; k < N; k++)
      s[k] = c[k] ^ c[(k + 11) % N] ^ c[(k + 9) % N] ^ c[(k + 8) % N];
    return s;
  endfunction

  logic           busy;
  logic [K-1:0]   data_q;
  logic [1:0]     tries_q;
  logic [N-1:0]   cw_try;
  logic           bad, last;

  assign in_ready = !busy;
  assign cw_try   = encode(data_q) ^ {flip_req ? (P'(1) << flip_idx) : P'(0), K'(0)};
  assign bad      = |syndrome(cw_try);
  assign last     = (tries_q == 2'(MAX_TRIES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      data_q     <= '0;
      tries_q    <= '0;
      cw_valid   <= 1'b0;
      cw_data    <= '0;
      cw_retries <= '0;
      enc_fail   <= 1'b0;
    end else begin
      cw_valid <= 1'b0;
      if (!busy) begin
        if (in_valid) begin
          data_q  <= in_data;
          tries_q <= '0;
          busy    <= 1'b1;
        end
      end else if (!bad) begin
        cw_valid   <= 1'b1;
        cw_data    <= cw_try;
        cw_retries <= tries_q;
        busy       <= 1'b0;
      end else if (last) begin
        enc_fail <= 1'b1;
        busy     <= 1'b0;
      end else begin
        tries_q <= tries_q + 2'd1;
      end
    end
  end

  AST_DATA_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
    cw_valid |-> cw_data[K-1:0] == data_q);                          // R1
  AST_ZERO_SYNDROME: assert property (@(posedge clk) disable iff (!rst_n)
    cw_valid |-> syndrome(cw_data) == '0);                           // R3
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);                           // R4
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cw_valid |=> !cw_valid);                                         // R4
  AST_RETRY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cw_valid |-> cw_retries < 2'(MAX_TRIES));                        // R5
  AST_DROP_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(enc_fail) |-> !cw_valid);                                  // R6
  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    enc_fail |=> enc_fail);                                          // R7
endmodule

// File: tb/tb_ldpc_selfcheck_enc.sv
module tb_ldpc_selfcheck_enc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [6:0]  in_data = '0;
  logic        flip_req = 1'b0;
  logic [2:0]  flip_idx = '0;
  logic        cw_valid;
  logic [14:0] cw_data;
  logic [1:0]  cw_retries;
  logic        enc_fail;

  int checks = 0;
  int errors = 0;
  bit exp_fail = 1'b0;

  always #2 clk = ~clk;

  ldpc_selfcheck_enc dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .flip_req(flip_req), .flip_idx(flip_idx),
    .cw_valid(cw_valid), .cw_data(cw_data), .cw_retries(cw_retries),
    .enc_fail(enc_fail)
  );

  // entry: {data[6:0], faulted attempts[1:0], flip index[2:0]}
  localparam logic [11:0] VEC [12] = '{
    {7'h00, 2'd0, 3'd0}, {7'h01, 2'd0, 3'd0}, {7'h7F, 2'd0, 3'd0},
    {7'h40, 2'd0, 3'd0}, {7'h2A, 2'd1, 3'd0}, {7'h55, 2'd1, 3'd7},
    {7'h13, 2'd2, 3'd3}, {7'h6C, 2'd0, 3'd0}, {7'h3E, 2'd3, 3'd5},
    {7'h09, 2'd0, 3'd0}, {7'h71, 2'd2, 3'd6}, {7'h22, 2'd1, 3'd2}
  };

  function automatic logic [14:0] ref_cw(input logic [6:0] d);
    for (int u = 0; u < 128; u++) begin
      logic [14:0] p;
      p = '0;
      for (int j = 0; j < 7; j++)
        if (u[j]) p = p ^ (15'h01D1 << j);
      if (p[6:0] == d) return p;
    end
    return '0;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run(input logic [6:0] d, input int nf, input logic [2:0] idx);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; flip_idx = idx;
    @(posedge clk); #1;
    check("R4 busy after accept", 32'(in_ready), 0);
    for (int a = 0; a < 3; a++) begin
      @(negedge clk);
      in_valid = 1'b0;
      flip_req = (a < nf);
      @(posedge clk); #1;
      if (nf < 3) begin
        check("R4/R5 strobe timing", 32'(cw_valid), 32'(a == nf));
        if (a == nf) begin
          check("R1/R2 codeword", 32'(cw_data), 32'(ref_cw(d)));
          check("R5 retry count", 32'(cw_retries), 32'(nf));
          check("R4 ready after release", 32'(in_ready), 1);
          break;
        end
      end else begin
        check("R6 no strobe on failing attempt", 32'(cw_valid), 0);
      end
    end
    flip_req = 1'b0;
    if (nf >= 3) begin
      exp_fail = 1'b1;
      check("R6 ready after drop", 32'(in_ready), 1);
    end
    check("R6/R7 fail flag", 32'(enc_fail), 32'(exp_fail));
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
    $finish;
  end

  initial begin
    #1;
    check("R8 ready in reset", 32'(in_ready), 1);
    check("R8 strobe in reset", 32'(cw_valid), 0);
    check("R8 fail in reset", 32'(enc_fail), 0);
    #10 rst_n = 1'b1;
    foreach (VEC[i])
      run(VEC[i][11:5], int'(VEC[i][4:3]), VEC[i][2:0]);
    // R7: fail stays set and encoding continues, including with a flip
    run(7'h5A, 1, 3'd4);
    run(7'h7F, 0, 3'd0);
    // R5: a single flip on every parity position
    for (int p = 0; p < 8; p++) run(7'h37, 1, 3'(p));
    rst_n = 1'b0; #1;
    check("R8 fail cleared by reset", 32'(enc_fail), 0);
    check("R8 ready after reset", 32'(in_ready), 1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
    $finish;
  end
endmodule